// File: doc/BRIEF.md
# Reconfigurable Tree/Chain Scan Register

A bank of `NUM_FF` scan flip-flops that sits between a block of logic under test and its state inputs. In normal operation the bank captures the logic's parallel next-state vector on every clock and presents it straight back as the present-state vector. For test, the same flip-flops can be rewired into one of two shift topologies. Both are fed from a single serial input.

In tree topology the flip-flops form a binary tree, numbered breadth-first from 0. The serial input drives the root, and every other flop copies its parent. A complete load therefore takes only as many shifts as the tree has levels. The serial output is the XOR of the deepest level. In chain topology the flops form one serial chain from flop 0 to flop `NUM_FF-1`, and the last flop is the serial output. In both topologies the previous response is shifted out during the same clocks that shift the new vector in.

The topology is held in a small four-state controller: `ST_CAP_CHAIN`, `ST_CAP_TREE`, `ST_SHF_CHAIN` and `ST_SHF_TREE`. Any clock with shift enable low moves the controller to `ST_CAP_TREE` when the mode select is 1, or to `ST_CAP_CHAIN` when it is 0. Any clock with shift enable high moves `ST_CAP_x` to `ST_SHF_x`, and `ST_SHF_x` stays where it is. The topology therefore only changes at a capture clock. Reset enters `ST_CAP_CHAIN`.

Top module: `recfg_scan_reg`

## Requirements
- R1: While `rst_n` is low, `present_state` is all zeros, the topology is chain, and `scan_out` is 0.
- R2: A clock edge with `shift_en` = 0 loads `next_state` into the register, and the value appears on `present_state` right after that edge.
- R3: A clock edge with `shift_en` = 0 latches `mode_sel` (1 = tree, 0 = chain) as the topology used by the following shift clocks.
- R4: A change of `mode_sel` while `shift_en` = 1 has no effect on the shift topology until the next clock with `shift_en` = 0.
- R5: In tree topology, a shift clock loads `scan_in` into flop 0, and each flop i ≥ 1 takes the old value of flop (i-1)/2 (integer division).
- R6: In tree topology, L = ceil(log2(NUM_FF+1)) shifts fill the whole register. After shifting in bits b0 (first) to b(L-1), every flop at depth d holds b(L-1-d). The depth of flop i is floor(log2(i+1)).
- R7: In tree topology, `scan_out` is the XOR of flops 2^(L-1)-1 through NUM_FF-1 of `present_state`. It is combinational in the present state.
- R8: In chain topology, a shift clock loads `scan_in` into flop 0, and each flop i ≥ 1 takes the old value of flop i-1. NUM_FF shifts load a full vector, and the first bit shifted in ends in flop NUM_FF-1.
- R9: In chain topology, `scan_out` equals flop NUM_FF-1 of `present_state`.
- R10: Unloading overlaps loading. Over the NUM_FF chain shifts that load a new vector, `scan_out` sampled before each shift gives the captured response from flop NUM_FF-1 down to flop 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Single serial scan input |
| mode_sel | input | 1 | Topology request, 1 = tree, 0 = chain; sampled when shift_en is low |
| shift_en | input | 1 | 1 = shift in the latched topology, 0 = capture next_state |
| next_state | input | NUM_FF | Parallel next-state response from the logic under test |
| present_state | output | NUM_FF | Register contents, driving the logic's state inputs |
| scan_out | output | 1 | Serial scan output (deepest-level XOR in tree, last flop in chain) |

## Verification
Every change to the register contents and to the latched topology is due exactly one rising edge after the clock whose inputs cause it. `scan_out` follows the present state with no added delay. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It therefore compares `present_state` against a per-shift model of R5 or R8 at the point where each result is due. For the overlap checks, `scan_out` is read on the falling edge before each shift, so each sample reflects the contents that the coming edge is about to move.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    typedef enum logic [1:0] {
        ST_CAP_CHAIN = 2'b00,
        ST_CAP_TREE  = 2'b01,
        ST_SHF_CHAIN = 2'b10,
        ST_SHF_TREE  = 2'b11
    } tsr_state_e;

    // Number of tree levels needed to hold n flops.
    function automatic int unsigned tree_levels(input int unsigned n);
        return $clog2(n + 1);
    endfunction

    // Index of the first flop in the deepest tree level.
    function automatic int unsigned deep_first(input int unsigned n);
        return (1 << (tree_levels(n) - 1)) - 1;
    endfunction

endpackage

// File: rtl/tsr_mode_fsm.sv
module tsr_mode_fsm
    import tsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic mode_sel,
    output logic tree_sel
);

    tsr_state_e state_q;
    tsr_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CAP_CHAIN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: topology only re-evaluated on capture clocks
    always_comb begin
        state_d = state_q;
        if (!shift_en) begin
            state_d = mode_sel ? ST_CAP_TREE : ST_CAP_CHAIN;
        end else begin
            unique case (state_q)
                ST_CAP_CHAIN: state_d = ST_SHF_CHAIN;
                ST_CAP_TREE:  state_d = ST_SHF_TREE;
                ST_SHF_CHAIN: state_d = ST_SHF_CHAIN;
                ST_SHF_TREE:  state_d = ST_SHF_TREE;
                default:      state_d = ST_CAP_CHAIN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_CAP_TREE, ST_SHF_TREE:   tree_sel = 1'b1;
            ST_CAP_CHAIN, ST_SHF_CHAIN: tree_sel = 1'b0;
            default:                    tree_sel = 1'b0;
        endcase
    end

endmodule

// File: rtl/tsr_next_state.sv
module tsr_next_state #(
    parameter int unsigned NUM_FF = 14
) (
    input  logic [NUM_FF-1:0] cur_q,
    input  logic [NUM_FF-1:0] capture_vec,
    input  logic              scan_in,
    input  logic              shift_en,
    input  logic              tree_sel,
    output logic [NUM_FF-1:0] nxt_q
);

    logic [NUM_FF-1:0] tree_vec;
    logic [NUM_FF-1:0] chain_vec;

    assign tree_vec[0]  = scan_in;
    assign chain_vec[0] = scan_in;

    generate
        for (genvar i = 1; i < NUM_FF; i++) begin : g_link
            localparam int unsigned PARENT = (i - 1) / 2;
            assign tree_vec[i]  = cur_q[PARENT];
            assign chain_vec[i] = cur_q[i-1];
        end
    endgenerate

    always_comb begin
        if (!shift_en) begin
            nxt_q = capture_vec;
        end else if (tree_sel) begin
            nxt_q = tree_vec;
        end else begin
            nxt_q = chain_vec;
        end
    end

endmodule

// File: rtl/tsr_unload.sv
module tsr_unload
    import tsr_pkg::*;
#(
    parameter int unsigned NUM_FF = 14
) (
    input  logic [NUM_FF-1:0] cur_q,
    input  logic              tree_sel,
    output logic              scan_out
);

    localparam int unsigned DEEP_LO = deep_first(NUM_FF);

    logic deep_xor;

    always_comb begin
        deep_xor = 1'b0;
        for (int unsigned k = DEEP_LO; k < NUM_FF; k++) begin
            deep_xor = deep_xor ^ cur_q[k];
        end
    end

    assign scan_out = tree_sel ? deep_xor : cur_q[NUM_FF-1];

endmodule

// File: rtl/recfg_scan_reg.sv
module recfg_scan_reg #(
    parameter int unsigned NUM_FF = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_in,
    input  logic              mode_sel,
    input  logic              shift_en,
    input  logic [NUM_FF-1:0] next_state,
    output logic [NUM_FF-1:0] present_state,
    output logic              scan_out
);

    logic              tree_sel;
    logic [NUM_FF-1:0] flops_q;
    logic [NUM_FF-1:0] flops_d;

    tsr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .mode_sel (mode_sel),
        .tree_sel (tree_sel)
    );

    tsr_next_state #(.NUM_FF(NUM_FF)) u_next (
        .cur_q       (flops_q),
        .capture_vec (next_state),
        .scan_in     (scan_in),
        .shift_en    (shift_en),
        .tree_sel    (tree_sel),
        .nxt_q       (flops_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flops_q <= '0;
        end else begin
            flops_q <= flops_d;
        end
    end

    tsr_unload #(.NUM_FF(NUM_FF)) u_unload (
        .cur_q    (flops_q),
        .tree_sel (tree_sel),
        .scan_out (scan_out)
    );

    assign present_state = flops_q;

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker
    import tsr_pkg::*;
#(
    parameter int unsigned NUM_FF = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_in,
    input logic              mode_sel,
    input logic              shift_en,
    input logic [NUM_FF-1:0] next_state,
    input logic [NUM_FF-1:0] present_state,
    input logic              scan_out,
    input logic              tree_sel
);

    localparam int unsigned DEEP_LO = deep_first(NUM_FF);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (present_state == '0 && !tree_sel); // R1
        end
    end

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> present_state == $past(next_state)); // R2

    AST_MODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> tree_sel == $past(mode_sel)); // R3

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> tree_sel == $past(tree_sel)); // R4

    AST_ROOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> present_state[0] == $past(scan_in)); // R5

    generate
        for (genvar i = 1; i < NUM_FF; i++) begin : g_links
            AST_TREE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_en && tree_sel) |=> present_state[i] == $past(present_state[(i-1)/2])); // R5
            AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
                (shift_en && !tree_sel) |=> present_state[i] == $past(present_state[i-1])); // R8
        end
    endgenerate

    AST_TREE_SOUT: assert property (@(posedge clk) disable iff (!rst_n)
        tree_sel |-> scan_out == ^present_state[NUM_FF-1:DEEP_LO]); // R7

    AST_CHAIN_SOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !tree_sel |-> scan_out == present_state[NUM_FF-1]); // R9

endmodule

bind recfg_scan_reg tsr_checker #(.NUM_FF(NUM_FF)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_in       (scan_in),
    .mode_sel      (mode_sel),
    .shift_en      (shift_en),
    .next_state    (next_state),
    .present_state (present_state),
    .scan_out      (scan_out),
    .tree_sel      (tree_sel)
);

// File: tb/recfg_scan_reg_bench.sv
module recfg_scan_reg_bench;

    localparam int unsigned F       = 14;
    localparam int unsigned LEVELS  = $clog2(F + 1);
    localparam int unsigned DEEP_LO = (1 << (LEVELS - 1)) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_in = 1'b0;
    logic         mode_sel = 1'b0;
    logic         shift_en = 1'b0;
    logic [F-1:0] next_state = '0;
    logic [F-1:0] present_state;
    logic         scan_out;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    recfg_scan_reg #(.NUM_FF(F)) u_recfg_scan_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_in       (scan_in),
        .mode_sel      (mode_sel),
        .shift_en      (shift_en),
        .next_state    (next_state),
        .present_state (present_state),
        .scan_out      (scan_out)
    );

    task automatic chk(input string req, input logic [F-1:0] act, input logic [F-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One rising edge, then return on the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [F-1:0] tree_model(input logic [F-1:0] v, input logic b);
        logic [F-1:0] r = v;
        for (int i = F - 1; i >= 1; i--) r[i] = r[(i-1)/2];
        r[0] = b;
        return r;
    endfunction

    function automatic logic [F-1:0] chain_model(input logic [F-1:0] v, input logic b);
        logic [F-1:0] r = v;
        for (int i = F - 1; i >= 1; i--) r[i] = r[i-1];
        r[0] = b;
        return r;
    endfunction

    function automatic logic deep_x(input logic [F-1:0] v);
        logic x = 1'b0;
        for (int k = DEEP_LO; k < F; k++) x ^= v[k];
        return x;
    endfunction

    task automatic capture(input logic [F-1:0] v, input logic m);
        shift_en   = 1'b0;
        next_state = v;
        mode_sel   = m;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #35;
        chk("R1 state", present_state, '0);
        chk("R1 scan_out", F'(scan_out), '0);
        @(negedge clk);
        rst_n = 1'b1;
        // first shift after reset must use chain topology
        shift_en = 1'b1;
        scan_in  = 1'b1;
        step();
        chk("R1 chain after reset", present_state, F'(1));
    endtask

    task automatic t_capture();
        capture(14'h2A5C, 1'b0);
        chk("R2 pattern a", present_state, 14'h2A5C);
        capture(14'h3FFF, 1'b0);
        chk("R2 pattern b", present_state, 14'h3FFF);
        capture(14'h0001, 1'b1);
        chk("R2 pattern c", present_state, 14'h0001);
    endtask

    task automatic t_tree_load();
        logic [LEVELS-1:0] bits = 4'b1101; // b0 = bit 0 shifted first
        logic [F-1:0] exp;
        capture(14'h0000, 1'b1);
        shift_en = 1'b1;
        for (int s = 0; s < LEVELS; s++) begin
            scan_in = bits[s];
            step();
        end
        for (int i = 0; i < F; i++) exp[i] = bits[LEVELS - 1 - ($clog2(i + 2) - 1)];
        chk("R6 tree full load", present_state, exp);
        chk("R7 tree scan_out after load", F'(scan_out), F'(deep_x(exp)));
    endtask

    task automatic t_tree_overlap();
        logic [F-1:0] exp = 14'h1B6D;
        capture(exp, 1'b1);
        chk("R7 scan_out of captured response", F'(scan_out), F'(deep_x(exp)));
        shift_en = 1'b1;
        for (int s = 0; s < 5; s++) begin
            scan_in = s[0];
            exp = tree_model(exp, s[0]);
            step();
            chk("R5 tree shift", present_state, exp);
            chk("R7 tree scan_out", F'(scan_out), F'(deep_x(exp)));
        end
    endtask

    task automatic t_mode_ignored();
        logic [F-1:0] exp = 14'h0F0F;
        capture(exp, 1'b0);
        shift_en = 1'b1;
        for (int s = 0; s < 3; s++) begin
            mode_sel = ~mode_sel;
            scan_in  = 1'b1;
            exp = chain_model(exp, 1'b1);
            step();
        end
        chk("R4 chain held during mode toggles", present_state, exp);
        exp = 14'h3001;
        capture(exp, 1'b1);
        chk("R3 capture latched", present_state, exp);
        shift_en = 1'b1;
        for (int s = 0; s < 3; s++) begin
            mode_sel = ~mode_sel;
            scan_in  = 1'b0;
            exp = tree_model(exp, 1'b0);
            step();
        end
        chk("R4 tree held during mode toggles", present_state, exp);
        chk("R3 tree topology scan_out", F'(scan_out), F'(deep_x(exp)));
    endtask

    task automatic t_chain_overlap();
        logic [F-1:0] resp = 14'h2C93;
        logic [F-1:0] vec  = 14'h15A6;
        logic [F-1:0] got  = '0;
        logic [F-1:0] exp_out;
        capture(resp, 1'b0);
        chk("R9 chain scan_out", F'(scan_out), F'(resp[F-1]));
        shift_en = 1'b1;
        for (int s = 0; s < F; s++) begin
            got[F-1-s] = scan_out;
            scan_in = vec[F-1-s];
            step();
        end
        exp_out = resp;
        chk("R10 unloaded response", got, exp_out);
        chk("R8 chain full load", present_state, vec);
        chk("R9 scan_out after load", F'(scan_out), F'(vec[F-1]));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_capture();
        t_tree_load();
        t_tree_overlap();
        t_mode_ignored();
        t_chain_overlap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule